// File: doc/BRIEF.md
# Sort-Based Destination Request Counter

This block sits on the input side of a multi-stage cell switch. In each cell slot it takes one cell from every input port of an input module. Each cell has a valid bit and the number of the output module it is heading for. The block reports how many of those cells want each output module. Those counts seed the path allocator that runs after it. The block also reports where the per-module marker landed in the sorted order, because later stages need that position to find the cells that belong to each module.

The counting does not use one counter per destination. The block mixes the cells with one marker item per output module and sorts everything in an odd-even merge network. The sort key puts the cells for module k first, then the marker for k, then module k+1; idle cells go last. It then does the following:
- Turns each marker into an active packet that carries its sorted position.
- Packs those packets in order into the low slots of a shift-based concentrator. Each concentrator stage takes two cycles: one registers the move decision, the other steers.
- Gets each count from a bit-serial adder as the current marker position plus the bitwise complement of the previous one.

A single `go` strobe starts one count. A single-cycle `cnt_valid` pulse presents the results, and they are held until the next pulse.

Top module: `dest_req_counter`

## Requirements
- R1: While reset is low and after it is released, `cnt_valid` is 0 and `cnt_out` and `mark_pos` are all zeros until the first result.
- R2: On the result strobe, the count field for module k (bits k*CW upward) equals the number of ports sampled with valid high and destination k.
- R3: A port with its valid bit low, or with a destination of NUM_MOD or more, adds to no count and moves no marker position.
- R4: On the result strobe, the position field for module k (bits k*PW upward) equals k plus the sum of the counts of modules 0 through k.
- R5: On the result strobe, count k equals position k minus position k-1 minus one, with position -1 taken as -1, so count 0 equals position 0.
- R6: `cnt_valid` is high for exactly one cycle, LAT = 3*PW+3 rising edges after the edge that samples `go` high. PW is the base-2 logarithm of the smallest power of two that is not below NUM_IN+NUM_MOD.
- R7: A `go` that arrives while a count is in progress is ignored. Only one strobe follows, and it carries the results of the first sample.
- R8: `cnt_out` and `mark_pos` keep their values on every cycle in which `cnt_valid` is low.
- R9: Boundary cases are exact. If all ports are idle, the counts are zero and positions 0..NUM_MOD-1 are reported. If all ports target one module, that module's count is NUM_IN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| go | input | 1 | Sample the cell vector and start a count |
| cell_valid | input | NUM_IN | Per-port valid bit; low marks an idle port |
| cell_dest | input | NUM_IN*DW | Per-port destination module; port i in bits i*DW upward |
| cnt_valid | output | 1 | One-cycle strobe marking new results |
| cnt_out | output | NUM_MOD*CW | Request count per output module |
| mark_pos | output | NUM_MOD*PW | Sorted position of each module's marker |

## Verification
The bench targets these corner cases:
- Every port aimed at the last module. This places the final marker at the top of the packed range.
- Every port aimed at module 0. Here the complement input of the first subtraction matters: a constant of the wrong sign there gives a count that is off by one.
- All ports idle, and destinations beyond the last module. If those cells are sorted as data, the markers move and some counts grow.
- A second `go` during a count. A design that restarts would emit the second vector's counts, or two strobes.

It also checks that the strobe arrives at the computed latency. A missing concentrator stage or an extra adder cycle would shift it.

// File: rtl/drc_pkg.sv
package drc_pkg;
   // Two low key bits: item class. Order matters: data sorts below marker,
   // idle sorts above everything.
   localparam logic [1:0] CLS_DATA = 2'b00;
   localparam logic [1:0] CLS_MARK = 2'b01;
   localparam logic [1:0] CLS_IDLE = 2'b11;
endpackage

// File: rtl/drc_sort_net.sv
module drc_sort_net #(
   parameter int N  = 16,
   parameter int KW = 4
) (
   input  logic [N-1:0][KW-1:0] keys_i,
   output logic [N-1:0][KW-1:0] keys_o
);
   logic [N-1:0][KW-1:0] v;

   // Batcher odd-even merge network, unrolled at elaboration.
   always_comb begin
      logic [KW-1:0] t;
      t = '0;
      v = keys_i;
      for (int p = 1; p < N; p = p * 2) begin
         for (int k = p; k >= 1; k = k / 2) begin
            for (int j = k % p; j < N - k; j = j + 2 * k) begin
               for (int i = 0; i < k; i++) begin
                  if ((i + j + k) < N && ((i + j) / (2 * p)) == ((i + j + k) / (2 * p))) begin
                     if (v[i+j] > v[i+j+k]) begin
                        t        = v[i+j];
                        v[i+j]   = v[i+j+k];
                        v[i+j+k] = t;
                     end
                  end
               end
            end
         end
      end
      keys_o = v;
   end
endmodule

// File: rtl/drc_concentrator.sv
module drc_concentrator #(
   parameter int N  = 16,
   parameter int PW = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         act_i,
   input  logic [N-1:0][PW-1:0] pos_i,
   input  logic [N-1:0][PW-1:0] sh_i,
   output logic [N-1:0][PW-1:0] pos_o
);
   logic [PW:0][N-1:0]         st_act;
   logic [PW:0][N-1:0][PW-1:0] st_pos;
   logic [PW:0][N-1:0][PW-1:0] st_sh;

   assign st_act[0] = act_i;
   assign st_pos[0] = pos_i;
   assign st_sh[0]  = sh_i;

   for (genvar b = 0; b < PW; b++) begin : g_stage
      localparam int D = 1 << b;
      logic [N-1:0]         ta_act, ta_mv, nx_act;
      logic [N-1:0][PW-1:0] ta_pos, ta_sh, nx_pos, nx_sh;
      logic [N-1:0]         tb_act;
      logic [N-1:0][PW-1:0] tb_pos, tb_sh;

      // cycle one: test activity and the shift bit of this stage
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ta_act <= '0;
            ta_mv  <= '0;
            ta_pos <= '0;
            ta_sh  <= '0;
         end else begin
            ta_act <= st_act[b];
            ta_pos <= st_pos[b];
            ta_sh  <= st_sh[b];
            for (int i = 0; i < N; i++)
               ta_mv[i] <= st_act[b][i] & st_sh[b][i][b];
         end
      end

      // cycle two: steer down by D where the bit is set
      for (genvar o = 0; o < N; o++) begin : g_slot
         if (o + D < N) begin : g_up
            always_comb begin
               if (ta_mv[o+D]) begin
                  nx_act[o] = 1'b1;
                  nx_pos[o] = ta_pos[o+D];
                  nx_sh[o]  = ta_sh[o+D];
               end else begin
                  nx_act[o] = ta_act[o] & ~ta_mv[o];
                  nx_pos[o] = ta_pos[o];
                  nx_sh[o]  = ta_sh[o];
               end
            end
         end else begin : g_top
            always_comb begin
               nx_act[o] = ta_act[o] & ~ta_mv[o];
               nx_pos[o] = ta_pos[o];
               nx_sh[o]  = ta_sh[o];
            end
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tb_act <= '0;
            tb_pos <= '0;
            tb_sh  <= '0;
         end else begin
            tb_act <= nx_act;
            tb_pos <= nx_pos;
            tb_sh  <= nx_sh;
         end
      end

      assign st_act[b+1] = tb_act;
      assign st_pos[b+1] = tb_pos;
      assign st_sh[b+1]  = tb_sh;
   end

   // inactive slots carry zero position, so packed slots are clean
   for (genvar o = 0; o < N; o++) begin : g_out
      assign pos_o[o] = st_act[PW][o] ? st_pos[PW][o] : '0;
   end
endmodule

// File: rtl/drc_serial_sub.sv
module drc_serial_sub #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic         step_i,
   input  logic [W-1:0] upper_i,
   input  logic [W-1:0] lower_i,
   output logic [W-1:0] diff_o
);
   logic [W-1:0] a_sr, b_sr, res;
   logic         cy;
   logic         s_bit, c_nx;

   assign s_bit = a_sr[0] ^ b_sr[0] ^ cy;
   assign c_nx  = (a_sr[0] & b_sr[0]) | (cy & (a_sr[0] ^ b_sr[0]));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_sr <= '0;
         b_sr <= '0;
         res  <= '0;
         cy   <= 1'b0;
      end else if (load_i) begin
         a_sr <= upper_i;
         b_sr <= ~lower_i;          // inverted lower input
         cy   <= 1'b0;
      end else if (step_i) begin
         res  <= {s_bit, res[W-1:1]};
         a_sr <= a_sr >> 1;
         b_sr <= b_sr >> 1;
         cy   <= c_nx;
      end
   end

   assign diff_o = res;
endmodule

// File: rtl/dest_req_counter.sv
module dest_req_counter #(
   parameter int NUM_IN  = 8,
   parameter int NUM_MOD = 3,
   localparam int DW        = (NUM_MOD > 1) ? $clog2(NUM_MOD) : 1,
   localparam int NUM_ITEMS = NUM_IN + NUM_MOD,
   localparam int PW        = $clog2(NUM_ITEMS),
   localparam int CW        = $clog2(NUM_IN + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   go,
   input  logic [NUM_IN-1:0]      cell_valid,
   input  logic [NUM_IN*DW-1:0]   cell_dest,
   output logic                   cnt_valid,
   output logic [NUM_MOD*CW-1:0]  cnt_out,
   output logic [NUM_MOD*PW-1:0]  mark_pos
);
   import drc_pkg::*;

   localparam int S          = 1 << PW;
   localparam int KW         = DW + 2;
   localparam int LOAD_AT    = 2 + 2 * PW;
   localparam int STEP_FIRST = LOAD_AT + 1;
   localparam int STEP_LAST  = LOAD_AT + PW;
   localparam int LAT        = STEP_LAST + 1;
   localparam int CTRW       = $clog2(LAT + 1);
   localparam logic [KW-1:0] IDLE_KEY = {{DW{1'b1}}, CLS_IDLE};

   if (NUM_MOD < 2) begin : g_bad_mod
      $error("NUM_MOD must be at least 2");
   end
   if (NUM_IN < 1) begin : g_bad_in
      $error("NUM_IN must be at least 1");
   end

   // sequence control
   logic [CTRW-1:0] ctr;
   logic            start;
   assign start = go && (ctr == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)                   ctr <= '0;
      else if (start)               ctr <= CTRW'(1);
      else if (ctr == CTRW'(LAT))   ctr <= '0;
      else if (ctr != '0)           ctr <= ctr + 1'b1;
   end

   // key build: cells, markers, padding
   logic [S-1:0][KW-1:0] key_d, key_q, sorted, sort_q;

   for (genvar gi = 0; gi < S; gi++) begin : g_key
      if (gi < NUM_IN) begin : g_cell
         assign key_d[gi] = (cell_valid[gi] &&
                             ({1'b0, cell_dest[gi*DW +: DW]} < (DW+1)'(NUM_MOD)))
                            ? {cell_dest[gi*DW +: DW], CLS_DATA} : IDLE_KEY;
      end else if (gi < NUM_ITEMS) begin : g_mark
         assign key_d[gi] = {DW'(gi - NUM_IN), CLS_MARK};
      end else begin : g_pad
         assign key_d[gi] = IDLE_KEY;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      key_q <= {S{IDLE_KEY}};
      else if (start)  key_q <= key_d;
   end

   drc_sort_net #(.N(S), .KW(KW)) u_sort (
      .keys_i (key_q),
      .keys_o (sorted)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) sort_q <= {S{IDLE_KEY}};
      else        sort_q <= sorted;
   end

   // packet generation: only markers are active; shift = idle/data below
   logic [S-1:0]         pk_act;
   logic [S-1:0][PW-1:0] pk_pos, pk_sh;

   always_comb begin
      int n_act;
      n_act = 0;
      for (int i = 0; i < S; i++) begin
         pk_act[i] = (sort_q[i][1:0] == CLS_MARK);
         pk_pos[i] = PW'(i);
         pk_sh[i]  = PW'(i - n_act);
         if (pk_act[i]) n_act = n_act + 1;
      end
   end

   logic [S-1:0][PW-1:0] conc_pos;

   drc_concentrator #(.N(S), .PW(PW)) u_conc (
      .clk   (clk),
      .rst_n (rst_n),
      .act_i (pk_act),
      .pos_i (pk_pos),
      .sh_i  (pk_sh),
      .pos_o (conc_pos)
   );

   // serial differences of adjacent marker positions
   logic load, step;
   assign load = (ctr == CTRW'(LOAD_AT));
   assign step = (ctr >= CTRW'(STEP_FIRST)) && (ctr <= CTRW'(STEP_LAST));

   logic [NUM_MOD-1:0][PW-1:0] diff;

   for (genvar k = 0; k < NUM_MOD; k++) begin : g_sub
      logic [PW-1:0] lower;
      if (k == 0) begin : g_first
         assign lower = '1;            // position -1
      end else begin : g_next
         assign lower = conc_pos[k-1];
      end
      drc_serial_sub #(.W(PW)) u_sub (
         .clk     (clk),
         .rst_n   (rst_n),
         .load_i  (load),
         .step_i  (step),
         .upper_i (conc_pos[k]),
         .lower_i (lower),
         .diff_o  (diff[k])
      );
   end

   // parallel result write
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_valid <= 1'b0;
         cnt_out   <= '0;
         mark_pos  <= '0;
      end else begin
         cnt_valid <= (ctr == CTRW'(LAT));
         if (ctr == CTRW'(LAT)) begin
            for (int k = 0; k < NUM_MOD; k++) begin
               cnt_out[k*CW +: CW]  <= diff[k][CW-1:0];
               mark_pos[k*PW +: PW] <= conc_pos[k];
            end
         end
      end
   end
endmodule

// File: rtl/dest_req_counter_chk.sv
module dest_req_counter_chk #(
   parameter int NUM_IN  = 8,
   parameter int NUM_MOD = 3,
   parameter int CW      = 4,
   parameter int PW      = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cnt_valid,
   input logic [NUM_MOD*CW-1:0] cnt_out,
   input logic [NUM_MOD*PW-1:0] mark_pos
);
   int sum_cnt;
   always_comb begin
      sum_cnt = 0;
      for (int k = 0; k < NUM_MOD; k++)
         sum_cnt = sum_cnt + int'(cnt_out[k*CW +: CW]);
   end

   // R6
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_valid |=> !cnt_valid);

   // R8
   hold_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_valid |-> ($stable(cnt_out) && $stable(mark_pos)));

   // R3
   no_overcount_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_valid |-> (sum_cnt <= NUM_IN));

   // R4
   last_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_valid |-> (int'(mark_pos[(NUM_MOD-1)*PW +: PW]) == NUM_MOD - 1 + sum_cnt));

   for (genvar k = 0; k < NUM_MOD; k++) begin : g_gap
      int prev;
      if (k == 0) begin : g_z
         assign prev = -1;
      end else begin : g_n
         assign prev = int'(mark_pos[(k-1)*PW +: PW]);
      end
      // R5
      gap_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_valid |-> (int'(cnt_out[k*CW +: CW]) ==
                        int'(mark_pos[k*PW +: PW]) - prev - 1));
   end
endmodule

bind dest_req_counter dest_req_counter_chk #(
   .NUM_IN (NUM_IN),
   .NUM_MOD(NUM_MOD),
   .CW     (CW),
   .PW     (PW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cnt_valid(cnt_valid),
   .cnt_out  (cnt_out),
   .mark_pos (mark_pos)
);

// File: tb/dest_req_counter_bench.sv
`timescale 1ns/1ps
module dest_req_counter_bench;
   localparam int NUM_IN  = 8;
   localparam int NUM_MOD = 3;
   localparam int DW      = 2;
   localparam int CW      = 4;
   localparam int PW      = 4;
   localparam int LAT     = 3 * PW + 3;

   typedef struct {
      logic [NUM_MOD*CW-1:0] c;
      logic [NUM_MOD*PW-1:0] p;
      longint                t;
   } exp_t;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  go = 1'b0;
   logic [NUM_IN-1:0]     cell_valid = '0;
   logic [NUM_IN*DW-1:0]  cell_dest = '0;
   logic                  cnt_valid;
   logic [NUM_MOD*CW-1:0] cnt_out;
   logic [NUM_MOD*PW-1:0] mark_pos;

   int   checks = 0;
   int   errors = 0;
   int   stray  = 0;
   bit   done   = 1'b0;
   exp_t sb_q[$];

   always #4 clk = ~clk;

   dest_req_counter u_dest_req_counter (
      .clk(clk), .rst_n(rst_n), .go(go),
      .cell_valid(cell_valid), .cell_dest(cell_dest),
      .cnt_valid(cnt_valid), .cnt_out(cnt_out), .mark_pos(mark_pos)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // driver: computes expected values from the requirements and queues them
   task automatic send(input logic [NUM_IN-1:0] v, input logic [NUM_IN*DW-1:0] d,
                       input bit keep);
      exp_t e;
      int   cum;
      int   n;
      @(negedge clk);
      cell_valid = v;
      cell_dest  = d;
      go         = 1'b1;
      cum = 0;
      for (int k = 0; k < NUM_MOD; k++) begin
         n = 0;
         for (int i = 0; i < NUM_IN; i++)
            if (v[i] && int'(d[i*DW +: DW]) == k) n++;
         cum = cum + n;
         e.c[k*CW +: CW] = CW'(n);
         e.p[k*PW +: PW] = PW'(k + cum);
      end
      e.t = longint'($time);
      if (keep) sb_q.push_back(e);
      @(negedge clk);
      go = 1'b0;
   endtask

   task automatic drain();
      wait (sb_q.size() == 0);
      repeat (3) @(negedge clk);
   endtask

   // monitor: pops and compares on each strobe
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && cnt_valid) begin
            if (sb_q.size() == 0) begin
               stray++;
               chk(1'b0, "R7", "unexpected strobe", 1, 0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               // R6: sampled at the negedge after edge LAT
               chk(longint'($time) - e.t == longint'(8 * (LAT + 1)), "R6", "latency ns",
                   longint'($time) - e.t, longint'(8 * (LAT + 1)));
               for (int k = 0; k < NUM_MOD; k++) begin
                  // R2 / R5
                  chk(cnt_out[k*CW +: CW] == e.c[k*CW +: CW], "R2", $sformatf("count[%0d]", k),
                      longint'(cnt_out[k*CW +: CW]), longint'(e.c[k*CW +: CW]));
                  // R4
                  chk(mark_pos[k*PW +: PW] == e.p[k*PW +: PW], "R4", $sformatf("pos[%0d]", k),
                      longint'(mark_pos[k*PW +: PW]), longint'(e.p[k*PW +: PW]));
               end
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         chk(1'b0, "WATCHDOG", "run did not finish", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr;
      logic [NUM_MOD*CW-1:0] c_hold;
      logic [NUM_MOD*PW-1:0] p_hold;
      lfsr = 32'h1d2c_3b4a;

      repeat (4) @(negedge clk);
      // R1: during reset
      chk(cnt_valid == 1'b0, "R1", "strobe in reset", longint'(cnt_valid), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R1: after release
      chk(cnt_valid == 1'b0, "R1", "strobe after reset", longint'(cnt_valid), 0);
      chk(cnt_out == '0, "R1", "counts after reset", longint'(cnt_out), 0);
      chk(mark_pos == '0, "R1", "positions after reset", longint'(mark_pos), 0);

      // R2 mixed destinations, all valid: 4,2,2
      send(8'hff, {2'd0, 2'd2, 2'd0, 2'd1, 2'd0, 2'd1, 2'd2, 2'd0}, 1'b1);
      drain();
      // R3 idle ports mixed in
      send(8'b1010_0110, {2'd2, 2'd2, 2'd1, 2'd1, 2'd0, 2'd0, 2'd2, 2'd1}, 1'b1);
      drain();
      // R3 destination 3 is out of range and must be treated as idle
      send(8'hff, {2'd3, 2'd3, 2'd1, 2'd3, 2'd0, 2'd3, 2'd2, 2'd3}, 1'b1);
      drain();
      // R9 all to last module
      send(8'hff, {8{2'd2}}, 1'b1);
      drain();
      // R9 all idle
      send(8'h00, {8{2'd1}}, 1'b1);
      drain();
      // R9 all to module 0 (first subtraction edge)
      send(8'hff, {8{2'd0}}, 1'b1);
      drain();

      // R7: second go during a count is ignored
      send(8'h0f, {2'd0, 2'd0, 2'd0, 2'd0, 2'd2, 2'd1, 2'd1, 2'd0}, 1'b1);
      @(negedge clk);
      send(8'hff, {8{2'd2}}, 1'b0);
      drain();
      repeat (LAT + 4) @(negedge clk);
      chk(stray == 0, "R7", "extra strobes", longint'(stray), 0);

      // R8: outputs hold while no strobe
      c_hold = cnt_out;
      p_hold = mark_pos;
      cell_valid = 8'h5a;
      cell_dest  = 16'h9c3e;
      repeat (6) @(negedge clk);
      chk(cnt_out == c_hold, "R8", "counts held", longint'(cnt_out), longint'(c_hold));
      chk(mark_pos == p_hold, "R8", "positions held", longint'(mark_pos), longint'(p_hold));

      // R2 pseudo-random vectors (destination 3 read as idle by the model)
      for (int r = 0; r < 8; r++) begin
         logic [NUM_IN-1:0]    v;
         logic [NUM_IN*DW-1:0] d;
         for (int s = 0; s < 24; s++) lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         v = lfsr[7:0];
         d = lfsr[23:8];
         for (int i = 0; i < NUM_IN; i++)
            if (d[i*DW +: DW] == 2'd3) v[i] = 1'b0;
         send(v, d, 1'b1);
         drain();
      end

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule